// File: doc/BRIEF.md
# Address-Gated Serial Peripheral Port

This block is the receive/transmit front end of a serial peripheral port. It acts only as a slave. An external master provides the serial clock, an active-low select, and the data line into the slave. Each select assertion carries one eight-bit frame, most significant bit first.

The first three bits of a frame are a device address. The block compares them with the identity given by two strap pins and a fixed top bit, and the decision is made as the third bit arrives. On a match, the block loads a five-bit status word and sends it on the return data line during the rest of the same frame. On a mismatch, or before the decision, the return line stays released. Several of these slaves can therefore share one select and one return line.

When the select is released after exactly eight bits of an addressed frame, the whole received byte goes to a command output. A single-cycle strobe marks the update. Decoding of the command is left to downstream logic. All serial inputs are brought into the system clock domain through two-flop synchronisers, and both clock edges are detected there.

Top module: `addr_spi_slave`

## Requirements
- R1: While chip select is high, the return line is released (`spi_miso_oe` = 0), and serial clock activity leaves the frame state and command output untouched.
- R2: A falling chip select clears the bit counter and the receive shift register, so a frame that was cut short has no effect on the next frame.
- R3: Bits are taken MSB first. The first three bits, B7, B6 and B5, must equal {`FIXED_ID_BIT`, `id_strap[1]`, `id_strap[0]`}. `FIXED_ID_BIT` defaults to 1.
- R4: The return line stays released during the first three bits of every frame. It stays released for the whole frame when the address differs.
- R5: After a match, the line carries `status_in[4]` down to `status_in[0]`. Each bit is valid at serial rising edges four to eight, and it changes only on serial falling edges.
- R6: The status word is captured at the moment of the address match. Later changes on `status_in` do not alter the bits sent in that frame.
- R7: `cmd_out` takes the full received byte, with `cmd_valid` high for exactly one system cycle, only when select rises after exactly eight bits of a matching frame. Frames of other lengths leave `cmd_out` unchanged.
- R8: A frame whose address does not match never updates `cmd_out` and raises no strobe.
- R9: The master may idle the serial clock either low or high. Data is captured on serial rising edges in both cases.
- R10: After reset, `cmd_out` is 0, `cmd_valid` is 0 and the return line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data into the slave |
| spi_miso | output | 1 | Serial data out, high impedance when not driving |
| spi_miso_oe | output | 1 | High while `spi_miso` is actively driven |
| id_strap | input | 2 | Strap pins forming the low two address bits |
| status_in | input | 5 | Read-only status word sent after a match |
| cmd_out | output | 8 | Last accepted command byte |
| cmd_valid | output | 1 | One-cycle strobe on a `cmd_out` update |

## Verification
The assertions assume that select and serial clock never change within the same few system cycles. They also assume that each serial clock phase lasts at least four system cycles, so every synchronised edge is seen and the rising and falling pulses never overlap. The stimulus holds every serial half period at four system cycles. It waits several cycles between a select edge and the first clock edge, and it changes data only together with the falling clock. Status and strap inputs are changed only at points where the requirements define the outcome.

// File: rtl/addr_spi_pkg.sv
// Shared frame geometry for the address-gated serial port.
// Assumes an address field no wider than the frame.
package addr_spi_pkg;
    localparam int FRAME_BITS = 8;
    localparam int ADDR_BITS  = 3;
    localparam int STRAP_BITS = ADDR_BITS - 1;
    localparam int STAT_BITS  = FRAME_BITS - ADDR_BITS;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);

    typedef logic [CNT_W-1:0] bitcnt_t;

    localparam bitcnt_t CNT_LAST_ADDR   = bitcnt_t'(ADDR_BITS - 1);
    localparam bitcnt_t CNT_ADDR_DONE   = bitcnt_t'(ADDR_BITS);
    localparam bitcnt_t CNT_FIRST_SHIFT = bitcnt_t'(ADDR_BITS + 1);
    localparam bitcnt_t CNT_FULL        = bitcnt_t'(FRAME_BITS);
    localparam bitcnt_t CNT_SAT         = bitcnt_t'(FRAME_BITS + 1);
endpackage

// File: rtl/addr_spi_sync.sv
// Multi-bit bank of independent flop-chain synchronisers.
// Assumes each bit is unrelated to the others, so no bus coherence is needed.
module addr_spi_sync #(
    parameter int               WIDTH     = 3,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the asynchronous bit through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RESET_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], d[b]};
        end

        assign q[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/addr_spi_edge.sv
// Turns a synchronised level into single-cycle rise and fall pulses.
// Assumes the input is already in the clk domain.
module addr_spi_edge #(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic prev_q;

    // Remember the level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RESET_VAL;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
endmodule

// File: rtl/addr_spi_rx.sv
// Receive side: bit counter, shift register, on-the-fly address check
// and the command register. Assumes at most one serial edge pulse per
// cycle and that select edges never coincide with clock edges.
module addr_spi_rx
    import addr_spi_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_active,
    input  logic                  cs_start,
    input  logic                  cs_end,
    input  logic                  sclk_rise,
    input  logic                  mosi,
    input  logic [ADDR_BITS-1:0]  exp_addr,
    output logic                  addr_hit,
    output logic                  match_q,
    output bitcnt_t               cnt_q,
    output logic [FRAME_BITS-1:0] cmd_out,
    output logic                  cmd_valid
);
    logic [FRAME_BITS-1:0] sr_q;
    logic                  take_bit;

    assign take_bit = cs_active & sclk_rise;
    assign addr_hit = take_bit && (cnt_q == CNT_LAST_ADDR)
                      && ({sr_q[ADDR_BITS-2:0], mosi} == exp_addr);

    // Count and shift incoming bits; reset both at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sr_q  <= '0;
        end else if (cs_start) begin
            cnt_q <= '0;
            sr_q  <= '0;
        end else if (take_bit) begin
            sr_q <= {sr_q[FRAME_BITS-2:0], mosi};
            if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Hold the address decision for the frame; drop it once select is idle.
    always_ff @(posedge clk) begin
        if (!rst_n)          match_q <= 1'b0;
        else if (!cs_active) match_q <= 1'b0;
        else if (addr_hit)   match_q <= 1'b1;
    end

    // Accept the byte only for a complete, addressed frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_out   <= '0;
            cmd_valid <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            if (cs_end && match_q && (cnt_q == CNT_FULL)) begin
                cmd_out   <= sr_q;
                cmd_valid <= 1'b1;
            end
        end
    end

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
    assert_valid_full_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(cnt_q) == CNT_FULL);
    assert_valid_needs_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(match_q));
    assert_match_on_third_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_q) |-> cnt_q == CNT_ADDR_DONE);
    assert_idle_no_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> $stable(cnt_q));
endmodule

// File: rtl/addr_spi_tx.sv
// Transmit side: captures the status word on an address hit and moves
// it out one bit per serial falling edge. Assumes the hit pulse and
// falling-edge pulse never occur in the same cycle.
module addr_spi_tx
    import addr_spi_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 sclk_fall,
    input  logic                 cs_active,
    input  bitcnt_t              cnt,
    input  logic [STAT_BITS-1:0] status_in,
    output logic                 tx_bit
);
    logic [STAT_BITS-1:0] sr_q;
    logic                 step;

    assign step = sclk_fall && cs_active
                  && (cnt >= CNT_FIRST_SHIFT) && (cnt < CNT_FULL);

    // Load the status snapshot, then advance once per falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    sr_q <= '0;
        else if (load) sr_q <= status_in;
        else if (step) sr_q <= {sr_q[STAT_BITS-2:0], 1'b0};
    end

    assign tx_bit = sr_q[STAT_BITS-1];

    assert_hold_between_falls_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !sclk_fall) |=> $stable(sr_q));
    assert_snapshot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> sr_q == $past(status_in));
endmodule

// File: rtl/addr_spi_slave.sv
// Top of the address-gated serial slave. Synchronises the serial pins,
// finds clock and select edges, and joins the receive and transmit sides.
// Assumes clk runs at least four times the serial clock rate.
module addr_spi_slave
    import addr_spi_pkg::*;
#(
    parameter logic FIXED_ID_BIT = 1'b1,
    parameter int   SYNC_STAGES  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  spi_sclk,
    input  logic                  spi_cs_n,
    input  logic                  spi_mosi,
    output logic                  spi_miso,
    output logic                  spi_miso_oe,
    input  logic [STRAP_BITS-1:0] id_strap,
    input  logic [STAT_BITS-1:0]  status_in,
    output logic [FRAME_BITS-1:0] cmd_out,
    output logic                  cmd_valid
);
    logic    cs_n_s, sclk_s, mosi_s;
    logic    cs_rise, cs_fall, sclk_rise, sclk_fall;
    logic    addr_hit, match_q, tx_bit;
    bitcnt_t cnt_q;

    addr_spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)) sync_i (
        .clk(clk), .rst_n(rst_n),
        .d({spi_cs_n, spi_sclk, spi_mosi}),
        .q({cs_n_s, sclk_s, mosi_s})
    );

    addr_spi_edge #(.RESET_VAL(1'b1)) cs_edge_i (
        .clk(clk), .rst_n(rst_n), .lvl(cs_n_s), .rise(cs_rise), .fall(cs_fall)
    );

    addr_spi_edge #(.RESET_VAL(1'b0)) sclk_edge_i (
        .clk(clk), .rst_n(rst_n), .lvl(sclk_s), .rise(sclk_rise), .fall(sclk_fall)
    );

    addr_spi_rx rx_i (
        .clk(clk), .rst_n(rst_n),
        .cs_active(~cs_n_s), .cs_start(cs_fall), .cs_end(cs_rise),
        .sclk_rise(sclk_rise), .mosi(mosi_s),
        .exp_addr({FIXED_ID_BIT, id_strap}),
        .addr_hit(addr_hit), .match_q(match_q), .cnt_q(cnt_q),
        .cmd_out(cmd_out), .cmd_valid(cmd_valid)
    );

    addr_spi_tx tx_i (
        .clk(clk), .rst_n(rst_n),
        .load(addr_hit), .sclk_fall(sclk_fall), .cs_active(~cs_n_s),
        .cnt(cnt_q), .status_in(status_in), .tx_bit(tx_bit)
    );

    // The raw select also gates the driver, so release is immediate.
    assign spi_miso_oe = match_q & ~spi_cs_n;
    assign spi_miso    = spi_miso_oe ? tx_bit : 1'bz;

    assert_drive_needs_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        spi_miso_oe |-> match_q);
    assert_release_on_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !match_q);
endmodule

// File: tb/addr_spi_slave_tb_top.sv
module addr_spi_slave_tb_top;
    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic       spi_miso, spi_miso_oe;
    logic [1:0] id_strap = 2'b01;
    logic [4:0] status_in = '0;
    logic [7:0] cmd_out;
    logic       cmd_valid;

    int n_checks = 0, n_fail = 0;
    int pulses = 0;
    logic       prev_valid = 1'b0;
    logic [7:0] exp_cmd = 8'h00;
    logic [7:0] pulse_val = 8'h00;

    always #2.5 clk = ~clk;

    addr_spi_slave dut_i (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .id_strap(id_strap), .status_in(status_in),
        .cmd_out(cmd_out), .cmd_valid(cmd_valid)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Per-clock model: released line while idle (R1), strobe width one (R7).
    always @(negedge clk) begin
        if (rst_n) begin
            if (spi_cs_n) chk(spi_miso_oe == 1'b0, "R1", "oe while idle", {7'b0, spi_miso_oe}, 8'h00);
            if (cmd_valid) begin
                pulses++;
                pulse_val = cmd_out;
                if (prev_valid) chk(1'b0, "R7", "strobe longer than one cycle", 8'h1, 8'h0);
            end
            prev_valid = cmd_valid;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One master frame; checks the return line at each rising edge.
    task automatic frame(input logic [7:0] b, input int nbits, input bit idle_hi,
                         input logic [4:0] stat, input int flip_at, input string req);
        bit hit;
        hit = (b[7:5] == {1'b1, id_strap}) && nbits >= 3;
        status_in = stat;
        spi_sclk = idle_hi;
        wait_cyc(4);
        spi_cs_n = 1'b0;
        wait_cyc(6);
        for (int i = 0; i < nbits; i++) begin
            spi_sclk = 1'b0;
            spi_mosi = (i < 8) ? b[7-i] : 1'b0;
            wait_cyc(HALF);
            if (i < 3 || !hit)
                chk(spi_miso_oe == 1'b0, "R4", "line released", {7'b0, spi_miso_oe}, 8'h00);
            else if (i < 8)
                chk(spi_miso_oe === 1'b1 && spi_miso === stat[7-i], req,
                    $sformatf("status bit %0d", 7 - i), {6'b0, spi_miso_oe, spi_miso},
                    {6'b0, 1'b1, stat[7-i]});
            spi_sclk = 1'b1;
            if (i == flip_at) status_in = ~stat;
            wait_cyc(HALF);
        end
        if (!idle_hi) spi_sclk = 1'b0;
        wait_cyc(HALF);
        spi_cs_n = 1'b1;
        wait_cyc(10);
    endtask

    // Run a frame and compare the command register against the model.
    task automatic run(input logic [7:0] b, input int nbits, input bit idle_hi,
                       input logic [4:0] stat, input int flip_at, input string req);
        bit upd;
        pulses = 0;
        upd = (b[7:5] == {1'b1, id_strap}) && nbits == 8;
        frame(b, nbits, idle_hi, stat, flip_at, req);
        if (upd) exp_cmd = b;
        chk(pulses == (upd ? 1 : 0), upd ? "R7" : "R8", "strobe count", 8'(pulses), upd ? 8'h1 : 8'h0);
        chk(cmd_out == exp_cmd, upd ? "R7" : "R8", "command value", cmd_out, exp_cmd);
        if (upd) chk(pulse_val == b, "R3", "byte at strobe", pulse_val, b);
    endtask

    initial begin
        wait_cyc(5);
        chk(cmd_out == 8'h00, "R10", "reset cmd_out", cmd_out, 8'h00);
        chk(cmd_valid == 1'b0, "R10", "reset cmd_valid", {7'b0, cmd_valid}, 8'h00);
        chk(spi_miso_oe == 1'b0, "R10", "reset line", {7'b0, spi_miso_oe}, 8'h00);
        rst_n = 1'b1;
        wait_cyc(5);

        // R3/R5/R9: matching frame, clock idles low; address 101 with strap 01
        run(8'hB6, 8, 1'b0, 5'b10011, -1, "R5");
        // R9: clock idles high, strap 10 -> address 110
        id_strap = 2'b10;
        run(8'hC9, 8, 1'b1, 5'b01101, -1, "R9");
        // R4/R8: wrong address, line never driven, no update
        run(8'h36, 8, 1'b0, 5'b11111, -1, "R4");
        // R7: short and long frames with a good address are dropped
        run(8'hD5, 5, 1'b0, 5'b10101, -1, "R7");
        run(8'hD5, 9, 1'b1, 5'b01010, -1, "R7");
        // R6: status changes after the match do not reach the line
        run(8'hCA, 8, 1'b0, 5'b11001, 4, "R6");
        // R2: aborted addressed frame, then a complete one
        run(8'hC0, 3, 1'b0, 5'b00110, -1, "R2");
        run(8'hC3, 8, 1'b0, 5'b00110, -1, "R2");
        // R3: strap change moves the identity; old address now misses
        id_strap = 2'b00;
        run(8'hC7, 8, 1'b0, 5'b10001, -1, "R3");
        run(8'h81, 8, 1'b1, 5'b10001, -1, "R3");

        // R1: clock and data toggled with select high change nothing
        pulses = 0;
        for (int i = 0; i < 10; i++) begin
            spi_sclk = ~spi_sclk;
            spi_mosi = ~spi_mosi;
            wait_cyc(HALF);
        end
        spi_sclk = 1'b0;
        wait_cyc(8);
        chk(pulses == 0, "R1", "no strobe while idle", 8'(pulses), 8'h0);
        chk(cmd_out == exp_cmd, "R1", "command held while idle", cmd_out, exp_cmd);
        run(8'h9E, 8, 1'b0, 5'b01011, -1, "R1");

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule